// File: doc/BRIEF.md
# ALU with post sign/zero extension

This block runs one logical or arithmetic operation on two 32-bit values and then narrows the result to a byte or a halfword. The narrowed value is widened back to 32 bits, either by copying its top bit upward or by clearing the upper bits. A type conversion that would otherwise take a separate instruction is folded into the operation itself. The first operand is always a register value. The second operand is a register, a register passed through a small barrel shifter, or an 8-bit immediate taken from the instruction.

The decoder drives the two instruction halfwords, both register values, the carry flag and a valid strobe. One clock later the block returns the extended result, the destination register index and an output strobe. An encoding that is recognised but not supported raises a one-cycle illegal flag instead of producing a result. An instruction without the form marker is not this block's business and produces nothing.

Top module: `post_ext_alu`

## Requirements
- R1: An input beat is taken only when `in_valid` is high and both `hw1[10]` and `hw1[9]` are 1. Any other beat leaves `out_valid` and `out_illegal` low in the next cycle and leaves `out_data` and `out_rd` unchanged.
- R2: `hw1[7:4]` selects the operation. The codes are 0 AND, 1 AND with inverted op2, 2 OR, 3 OR with inverted op2, 4 XOR, 5 ADD, 6 ADD with carry, 7 subtract with carry, 8 SUB (a-op2) and 9 reverse SUB.
- R3: Code 6 gives a+op2+carry_in. Code 7 gives a-op2-(1-carry_in). Code 9 gives op2-a. All sums wrap modulo 2^32.
- R4: `hw2[13:12]` selects op2: 01 is `rm_val`, 10 is `rm_val` shifted, and 11 is `hw2[7:0]` zero-extended. The value 00 is illegal.
- R5: For the shifted op2, `hw2[5:4]` selects the shift: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. `hw2[7:6]` gives the amount 0 to 3, and an amount of 0 passes `rm_val` through unchanged.
- R6: `hw2[15:14]` selects the extension of the operation result: 00 signed halfword (bit 15 copied into 31:16), 01 signed byte (bit 7 copied into 31:8), 10 unsigned halfword (31:16 cleared), 11 unsigned byte (31:8 cleared).
- R7: A taken beat with an operation code of 10 to 15, or with op2 select 00, drives `out_illegal` high for one cycle. In that cycle `out_valid` is low and `out_data` and `out_rd` are unchanged.
- R8: A taken legal beat produces `out_valid` high exactly one cycle later, with `out_data` holding the extended result and `out_rd` equal to `hw2[11:8]`.
- R9: While `rst_n` is low, `out_valid`, `out_illegal`, `out_data` and `out_rd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat strobe |
| hw1 | input | 16 | First instruction halfword |
| hw2 | input | 16 | Second instruction halfword |
| rn_val | input | 32 | First operand value |
| rm_val | input | 32 | Second register value |
| carry_in | input | 1 | Carry flag |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Unsupported encoding strobe |
| out_data | output | 32 | Extended result |
| out_rd | output | 4 | Destination register index |

## Verification
A wrong shifter or operation-select decode shows up at `out_data` in the very cycle after the faulty beat. The bench compares every beat against a model, so an error is caught one clock after it happens. Errors in the extension stage show as upper bits that disagree with the sign bit or that should be zero. Because the extension narrows the result, each operation is exercised under all four extension codes. A fault in the strobe or hold logic shows as a spurious `out_valid` or `out_illegal`, or as `out_data` or `out_rd` changing on a beat that is illegal or not taken.

// File: rtl/post_ext_alu.sv
module post_ext_alu #(
  parameter int XLEN = 32,
  parameter int IMMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [15:0]     hw1,
  input  logic [15:0]     hw2,
  input  logic [XLEN-1:0] rn_val,
  input  logic [XLEN-1:0] rm_val,
  input  logic            carry_in,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [XLEN-1:0] out_data,
  output logic [3:0]      out_rd
);
  localparam int HALF = 16;
  localparam int BYTE = 8;

  logic [3:0] op;
  logic [1:0] ext, osel, shtype, shamt;
  logic       take, legal;
  logic [XLEN-1:0] shifted, op2, alu, extd;
  logic [2*XLEN-1:0] rot2;

  assign op     = hw1[7:4];
  assign ext    = hw2[15:14];
  assign osel   = hw2[13:12];
  assign shtype = hw2[5:4];
  assign shamt  = hw2[7:6];
  assign take   = in_valid & hw1[10] & hw1[9];
  assign legal  = (op <= 4'd9) && (osel != 2'b00);
  assign rot2   = {rm_val, rm_val} >> shamt;

  always_comb begin
    case (shtype)
      2'b00:   shifted = rm_val << shamt;
      2'b01:   shifted = rm_val >> shamt;
      2'b10:   shifted = $signed(rm_val) >>> shamt;
      default: shifted = rot2[XLEN-1:0];
    endcase
  end

  always_comb begin
    case (osel)
      2'b10:   op2 = shifted;
      2'b11:   op2 = {{(XLEN-IMMW){1'b0}}, hw2[IMMW-1:0]};
      default: op2 = rm_val;
    endcase
  end

  always_comb begin
    case (op)
      4'd0:    alu = rn_val & op2;
      4'd1:    alu = rn_val & ~op2;
      4'd2:    alu = rn_val | op2;
      4'd3:    alu = rn_val | ~op2;
      4'd4:    alu = rn_val ^ op2;
      4'd5:    alu = rn_val + op2;
      4'd6:    alu = rn_val + op2 + {{(XLEN-1){1'b0}}, carry_in};
      4'd7:    alu = rn_val + ~op2 + {{(XLEN-1){1'b0}}, carry_in};
      4'd8:    alu = rn_val - op2;
      default: alu = op2 - rn_val;
    endcase
  end

  always_comb begin
    case (ext)
      2'b00:   extd = {{(XLEN-HALF){alu[HALF-1]}}, alu[HALF-1:0]};
      2'b01:   extd = {{(XLEN-BYTE){alu[BYTE-1]}}, alu[BYTE-1:0]};
      2'b10:   extd = {{(XLEN-HALF){1'b0}}, alu[HALF-1:0]};
      default: extd = {{(XLEN-BYTE){1'b0}}, alu[BYTE-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
      out_rd      <= '0;
    end else begin
      out_valid   <= take & legal;
      out_illegal <= take & ~legal;
      if (take & legal) begin
        out_data <= extd;
        out_rd   <= hw2[11:8];
      end
    end
  end
endmodule

// File: rtl/post_ext_alu_chk.sv
module post_ext_alu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [15:0]     hw1,
  input logic [15:0]     hw2,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [XLEN-1:0] out_data,
  input logic [3:0]      out_rd
);
  // R8
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hw1[10] && hw1[9] && hw1[7:4] <= 4'd9 && hw2[13:12] != 2'b00)
    |=> (out_valid && !out_illegal && out_rd == $past(hw2[11:8])));

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hw1[10] && hw1[9] && (hw1[7:4] > 4'd9 || hw2[13:12] == 2'b00))
    |=> (out_illegal && !out_valid && $stable(out_data) && $stable(out_rd)));

  // R1
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && hw1[10] && hw1[9])
    |=> (!out_valid && !out_illegal && $stable(out_data) && $stable(out_rd)));

  // R6
  sbyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(hw2[15:14]) == 2'b01) |-> (out_data[XLEN-1:8] == {(XLEN-8){out_data[7]}}));

  // R6
  ubyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(hw2[15:14]) == 2'b11) |-> (out_data[XLEN-1:8] == '0));

  // R6
  uhalf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(hw2[15:14]) == 2'b10) |-> (out_data[XLEN-1:16] == '0));

  // R7
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));
endmodule

bind post_ext_alu post_ext_alu_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hw1(hw1), .hw2(hw2),
  .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data), .out_rd(out_rd)
);

// File: tb/test_post_ext_alu.sv
module test_post_ext_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] hw1 = '0, hw2 = '0;
  logic [31:0] rn_val = '0, rm_val = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, out_illegal;
  logic [31:0] out_data;
  logic [3:0]  out_rd;

  int total = 0, bad = 0;
  logic        e_valid = 0, e_ill = 0;
  logic [31:0] e_data = 0;
  logic [3:0]  e_rd = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  post_ext_alu i_post_ext_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hw1(hw1), .hw2(hw2),
    .rn_val(rn_val), .rm_val(rm_val), .carry_in(carry_in),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data), .out_rd(out_rd)
  );

  function automatic logic [31:0] shift_ref(logic [31:0] v, int kind, int n);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: r = {r[30:0], 1'b0};
        1: r = {1'b0, r[31:1]};
        2: r = {r[31], r[31:1]};
        default: r = {r[0], r[31:1]};
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] model(logic [15:0] a1, logic [15:0] a2,
                                        logic [31:0] a, logic [31:0] m, logic c);
    longint x, y, r;
    logic [31:0] b, res;
    case (a2[13:12])
      2'b10: b = shift_ref(m, int'(a2[5:4]), int'(a2[7:6]));
      2'b11: b = {24'd0, a2[7:0]};
      default: b = m;
    endcase
    x = longint'(a); y = longint'(b);
    case (a1[7:4])
      0: r = x & y;
      1: r = x & (~y & 64'hFFFF_FFFF);
      2: r = x | y;
      3: r = x | (~y & 64'hFFFF_FFFF);
      4: r = x ^ y;
      5: r = x + y;
      6: r = x + y + longint'(c);
      7: r = x - y - (1 - longint'(c));
      8: r = x - y;
      default: r = y - x;
    endcase
    res = r[31:0];
    case (a2[15:14])
      2'b00: return res[15] ? (res | 32'hFFFF_0000) : (res & 32'h0000_FFFF);
      2'b01: return res[7] ? (res | 32'hFFFF_FF00) : (res & 32'h0000_00FF);
      2'b10: return res & 32'h0000_FFFF;
      default: return res & 32'h0000_00FF;
    endcase
  endfunction

  task automatic check_outputs(string tag);
    total++;
    if (out_valid !== e_valid || out_illegal !== e_ill) begin
      bad++;
      $display("FAIL %s strobes valid/illegal actual=%b/%b expected=%b/%b", tag, out_valid, out_illegal, e_valid, e_ill);
    end
    total++;
    if (out_data !== e_data || out_rd !== e_rd) begin
      bad++;
      $display("FAIL %s data/rd actual=%h/%0d expected=%h/%0d", tag, out_data, out_rd, e_data, e_rd);
    end
  endtask

  // drive one beat at a negedge; the result is checked at the following negedge
  task automatic beat(logic v, logic [15:0] a1, logic [15:0] a2,
                      logic [31:0] a, logic [31:0] m, logic c, string tag);
    in_valid = v; hw1 = a1; hw2 = a2; rn_val = a; rm_val = m; carry_in = c;
    @(negedge clk);
    if (v && a1[10] && a1[9]) begin
      if (a1[7:4] <= 4'd9 && a2[13:12] != 2'b00) begin
        e_valid = 1; e_ill = 0; e_data = model(a1, a2, a, m, c); e_rd = a2[11:8];
      end else begin
        e_valid = 0; e_ill = 1;
      end
    end else begin
      e_valid = 0; e_ill = 0;
    end
    check_outputs(tag);
  endtask

  function automatic logic [15:0] mk1(int op);
    return {5'b10100, 2'b11, 1'b0, op[3:0], 4'd3};
  endfunction

  function automatic logic [15:0] mk2(int ex, int sel, int rd, int lo8);
    return {ex[1:0], sel[1:0], rd[3:0], lo8[7:0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    e_valid = 0; e_ill = 0; e_data = 0; e_rd = 0;
    check_outputs("R9");
    rst_n = 1'b1;

    // R2 every operation, register operand, unsigned halfword
    for (int op = 0; op < 10; op++)
      beat(1, mk1(op), mk2(2, 1, op, 0), 32'h1234_F0F0, 32'h0F0F_3C3C, 0, "R2");
    // R3 carry and reverse forms with both carry values
    beat(1, mk1(6), mk2(0, 1, 1, 0), 32'h0000_7FFF, 32'h0000_0000, 1, "R3");
    beat(1, mk1(7), mk2(0, 1, 2, 0), 32'h0000_0010, 32'h0000_0010, 0, "R3");
    beat(1, mk1(7), mk2(0, 1, 2, 0), 32'h0000_0010, 32'h0000_0010, 1, "R3");
    beat(1, mk1(9), mk2(1, 1, 3, 0), 32'h0000_0005, 32'h0000_0003, 0, "R3");
    // R4 immediate operand
    beat(1, mk1(5), mk2(3, 3, 4, 8'hFF), 32'h0000_0001, 32'hDEAD_BEEF, 0, "R4");
    beat(1, mk1(2), mk2(0, 3, 5, 8'h80), 32'h0000_7F00, 32'hDEAD_BEEF, 0, "R4");
    // R5 every shift type and amount
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 4; n++)
        beat(1, mk1(5), mk2(2, 2, k, (n << 6) | (k << 4)), 32'h0, 32'h8000_8001, 0, "R5");
    // R6 every extension on sign-edge values
    for (int ex = 0; ex < 4; ex++) begin
      beat(1, mk1(4), mk2(ex, 1, 6, 0), 32'h0000_8080, 32'h0, 0, "R6");
      beat(1, mk1(4), mk2(ex, 1, 6, 0), 32'hFFFF_7F7F, 32'h0, 0, "R6");
    end
    // R7 illegal codes and operand select 00; data held
    beat(1, mk1(10), mk2(0, 1, 9, 0), 32'h1, 32'h1, 0, "R7");
    beat(1, mk1(15), mk2(0, 1, 9, 0), 32'h1, 32'h1, 0, "R7");
    beat(1, mk1(5), mk2(0, 0, 9, 0), 32'h1, 32'h1, 0, "R7");
    // R1 wrong form markers and idle strobe
    beat(1, mk1(5) & ~16'h0400, mk2(0, 1, 7, 0), 32'h55, 32'h1, 0, "R1");
    beat(1, mk1(5) & ~16'h0200, mk2(0, 1, 7, 0), 32'h55, 32'h1, 0, "R1");
    beat(0, mk1(5), mk2(0, 1, 7, 0), 32'h55, 32'h1, 0, "R1");
    // R8 back-to-back random stream
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a1, a2;
      a1 = 16'($urandom);
      if (i % 5 != 0) a1[10:9] = 2'b11;
      if (i % 7 != 0) a1[7:4] = 4'($urandom_range(0, 9));
      a2 = 16'($urandom);
      beat(($urandom % 8) != 0, a1, a2, $urandom, $urandom, 1'($urandom), "R8");
    end
    beat(0, 0, 0, 0, 0, 0, "R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule